// File: doc/BRIEF.md
# Firmware Flash Write-Protect Controller

This block sits between a host and the firmware flash interface and decides which host accesses reach the flash. A 16-bit control register holds two bits: a write-enable bit and a lock bit. While write-enable is clear, read requests reach the flash and write requests are dropped. While it is set, both kinds of request reach the flash. Once the lock bit is set it can only be cleared by reset. While the lock bit is set, switching write-enable on raises a one-cycle system-management interrupt request. Privileged management code can then check the change before any firmware update goes ahead.

A second register holds a sticky flag that records any write the gate has dropped. Software clears the flag by writing 1 to it. A dropped write still completes toward the requester, in the same cycle, with no flash access. Both registers use a plain configuration port with per-byte write enables. Register reads are combinational from the address.

Top module: `fwp_guard`

## Requirements
- R1: After reset the control register (at `CTRL_ADDR`, default 4Eh) reads 0000h, the status register (at `STAT_ADDR`, default 50h) reads 0000h, and `smi_pulse` is 0.
- R2: Control bits 15:2 and status bits 15:1 ignore writes and always read 0.
- R3: Control bit 1 is the lock bit. A write with `cfg_be[0]`=1 and data bit 1 = 1 sets it. A later write of 0 leaves it at 1, and only reset clears it.
- R4: Control bit 0 is the write-enable bit. A write with `cfg_be[0]`=1 loads it with data bit 0, either to 1 or to 0, and the new value reads back in the next cycle.
- R5: While write-enable is 0, a read request (`req_write`=0) is forwarded: `fl_valid` follows `req_valid` and `req_ready` follows `fl_ready`. A write request gives `fl_valid`=0 and `req_ready`=1 in the same cycle, whatever `fl_ready` is.
- R6: While write-enable is 1, write requests are forwarded with `fl_write`=1, and `req_ready` follows `fl_ready`.
- R7: A control write that changes write-enable from 0 to 1 while the lock bit was already 1 before that write makes `smi_pulse` 1 for exactly the one cycle after the write's clock edge.
- R8: No pulse occurs when the lock bit was 0 before the write. This holds even when the same write sets both bits. No pulse occurs when 1 is written over a write-enable that is already 1.
- R9: Status bit 0 becomes 1 in the cycle after a dropped write. A status write with `cfg_be[0]`=1 and data bit 0 = 1 clears it, and writing 0 leaves it unchanged. When a drop and a clear happen in the same cycle, the drop wins.
- R10: A register write with `cfg_be[0]`=0 leaves bits 1:0 of both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_be | input | REG_W/8 | Byte enables for the write |
| cfg_wdata | input | REG_W | Write data |
| cfg_rdata | output | REG_W | Read data for the addressed register (0 when no register matches) |
| req_valid | input | 1 | Host flash request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | FL_AW | Request address |
| req_wdata | input | FL_DW | Request write data |
| req_ready | output | 1 | Request accepted or completed |
| fl_valid | output | 1 | Forwarded request valid |
| fl_write | output | 1 | Forwarded request is a write |
| fl_addr | output | FL_AW | Forwarded address |
| fl_wdata | output | FL_DW | Forwarded write data |
| fl_ready | input | 1 | Flash side accepts the request |
| smi_pulse | output | 1 | One-cycle management interrupt request |

## Verification
The assertions assume that a register write and the request stream never depend on each other in the same cycle. They also assume that `fl_ready` is a plain input with no dependence on `fl_valid`. The bench meets both assumptions: it changes inputs only a fixed delay after a rising edge, and it drives `fl_ready` as a free level. The bench keeps the request inputs idle during register writes, so every pulse or flag change can be traced to a single stimulus. The one exception is the drop flag, where a dropped write and a clear in the same cycle are applied on purpose.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   localparam int WEN_BIT  = 0;
   localparam int LOCK_BIT = 1;
   localparam int DROP_BIT = 0;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } fwp_sel_e;
endpackage

// File: rtl/fwp_cfg_decode.sv
module fwp_cfg_decode
   import fwp_pkg::*;
#(
   parameter int          CFG_AW    = 8,
   parameter int          REG_W     = 16,
   parameter int unsigned CTRL_ADDR = 'h4E,
   parameter int unsigned STAT_ADDR = 'h50
) (
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  ctrl_val,
   input  logic              drop_val,
   output logic              wr_ctrl,
   output logic              wr_stat,
   output logic [REG_W-1:0]  rdata
);
   localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(CTRL_ADDR);
   localparam logic [CFG_AW-1:0] STAT_A = CFG_AW'(STAT_ADDR);

   fwp_sel_e sel;

   always_comb begin
      if (cfg_addr == CTRL_A)      sel = SEL_CTRL;
      else if (cfg_addr == STAT_A) sel = SEL_STAT;
      else                         sel = SEL_NONE;
   end

   assign wr_ctrl = cfg_wr && (sel == SEL_CTRL);
   assign wr_stat = cfg_wr && (sel == SEL_STAT);

   always_comb begin
      unique case (sel)
         SEL_CTRL: rdata = ctrl_val;
         SEL_STAT: rdata = {{(REG_W-1){1'b0}}, drop_val};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/fwp_ctrl_reg.sv
module fwp_ctrl_reg
   import fwp_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic               wr_stat,
   input  logic [REG_W-1:0]   wdata,
   input  logic [REG_W/8-1:0] be,
   input  logic               drop_set,
   output logic [REG_W-1:0]   ctrl,
   output logic               drop,
   output logic               smi
);
   localparam int               LANES   = REG_W / 8;
   localparam logic [REG_W-1:0] RW_MASK = REG_W'(2'b11);

   logic [REG_W-1:0] lane_mask;
   logic [REG_W-1:0] merged;
   logic [REG_W-1:0] ctrl_q, ctrl_d;
   logic             drop_q, drop_clr;
   logic             smi_q, smi_d;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = {8{be[g]}};
   end

   assign merged = ((ctrl_q & ~lane_mask) | (wdata & lane_mask)) & RW_MASK;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_ctrl) begin
         ctrl_d           = merged;
         ctrl_d[LOCK_BIT] = ctrl_q[LOCK_BIT] | merged[LOCK_BIT];
      end
   end

   assign smi_d    = wr_ctrl && ctrl_q[LOCK_BIT] && !ctrl_q[WEN_BIT] && ctrl_d[WEN_BIT];
   assign drop_clr = wr_stat && be[0] && wdata[DROP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         drop_q <= 1'b0;
         smi_q  <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         drop_q <= drop_set | (drop_q & ~drop_clr);
         smi_q  <= smi_d;
      end
   end

   assign ctrl = ctrl_q;
   assign drop = drop_q;
   assign smi  = smi_q;

   assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[LOCK_BIT] |=> ctrl_q[LOCK_BIT]);
   assert_smi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |-> ($past(ctrl_q[LOCK_BIT]) && ctrl_q[WEN_BIT] && !$past(ctrl_q[WEN_BIT])));
   assert_smi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |=> !smi_q);
   assert_lane_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !be[0]) |=> (ctrl_q == $past(ctrl_q)));
   assert_resvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[REG_W-1:2] == '0);
endmodule

// File: rtl/fwp_access_gate.sv
module fwp_access_gate #(
   parameter int FL_AW = 24,
   parameter int FL_DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [FL_AW-1:0] req_addr,
   input  logic [FL_DW-1:0] req_wdata,
   output logic             req_ready,
   output logic             fl_valid,
   output logic             fl_write,
   output logic [FL_AW-1:0] fl_addr,
   output logic [FL_DW-1:0] fl_wdata,
   input  logic             fl_ready,
   output logic             blocked
);
   assign blocked   = req_valid && req_write && !wen;
   assign fl_valid  = req_valid && !blocked;
   assign fl_write  = req_write;
   assign fl_addr   = req_addr;
   assign fl_wdata  = req_wdata;
   assign req_ready = blocked || fl_ready;

   assert_no_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && fl_write) |-> wen);
   assert_fwd_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fl_valid |-> req_valid);
   assert_drop_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !fl_valid) |-> req_ready);
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard #(
   parameter int          CFG_AW    = 8,
   parameter int          REG_W     = 16,
   parameter int unsigned CTRL_ADDR = 'h4E,
   parameter int unsigned STAT_ADDR = 'h50,
   parameter int          FL_AW     = 24,
   parameter int          FL_DW     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic               cfg_wr,
   input  logic [REG_W/8-1:0] cfg_be,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [FL_AW-1:0]   req_addr,
   input  logic [FL_DW-1:0]   req_wdata,
   output logic               req_ready,
   output logic               fl_valid,
   output logic               fl_write,
   output logic [FL_AW-1:0]   fl_addr,
   output logic [FL_DW-1:0]   fl_wdata,
   input  logic               fl_ready,
   output logic               smi_pulse
);
   if (REG_W < 8 || (REG_W % 8) != 0) begin : g_bad_width
      $error("REG_W must be a positive multiple of 8");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("CTRL_ADDR and STAT_ADDR must differ");
   end
   if (CTRL_ADDR >= (1 << CFG_AW) || STAT_ADDR >= (1 << CFG_AW)) begin : g_bad_range
      $error("register addresses exceed CFG_AW");
   end
   if (FL_AW < 1 || FL_DW < 1) begin : g_bad_flash
      $error("flash widths must be positive");
   end

   logic             wr_ctrl, wr_stat, drop, blocked;
   logic [REG_W-1:0] ctrl;

   fwp_cfg_decode #(
      .CFG_AW(CFG_AW), .REG_W(REG_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_dec (
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .ctrl_val(ctrl), .drop_val(drop),
      .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .rdata(cfg_rdata)
   );

   fwp_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
      .wdata(cfg_wdata), .be(cfg_be), .drop_set(blocked),
      .ctrl(ctrl), .drop(drop), .smi(smi_pulse)
   );

   fwp_access_gate #(.FL_AW(FL_AW), .FL_DW(FL_DW)) u_gate (
      .clk(clk), .rst_n(rst_n), .wen(ctrl[fwp_pkg::WEN_BIT]),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .fl_valid(fl_valid),
      .fl_write(fl_write), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_ready(fl_ready), .blocked(blocked)
   );

   assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> drop);
endmodule

// File: tb/fwp_guard_bench.sv
`timescale 1ns/1ps
module fwp_guard_bench;
   localparam int CFG_AW = 8;
   localparam int REG_W  = 16;
   localparam int FL_AW  = 24;
   localparam int FL_DW  = 8;
   localparam logic [7:0] CA = 8'h4E;
   localparam logic [7:0] SA = 8'h50;

   typedef enum int {K_RD, K_SMI, K_FV, K_RDY, K_FW, K_FA} kind_e;
   typedef struct {
      kind_e      kind;
      logic [31:0] exp;
      string      req;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CFG_AW-1:0] cfg_addr = '0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_be = '0;
   logic [REG_W-1:0] cfg_wdata = '0;
   logic [REG_W-1:0] cfg_rdata;
   logic req_valid = 1'b0, req_write = 1'b0, fl_ready = 1'b0;
   logic [FL_AW-1:0] req_addr = '0;
   logic [FL_DW-1:0] req_wdata = '0;
   logic req_ready, fl_valid, fl_write, smi_pulse;
   logic [FL_AW-1:0] fl_addr;
   logic [FL_DW-1:0] fl_wdata;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   item_t exp_q[$];

   always #2 clk = ~clk;

   fwp_guard u_fwp_guard (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .fl_valid(fl_valid),
      .fl_write(fl_write), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_ready(fl_ready), .smi_pulse(smi_pulse)
   );

   // monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = exp_q.pop_front();
         case (it.kind)
            K_RD:    act = 32'(cfg_rdata);
            K_SMI:   act = 32'(smi_pulse);
            K_FV:    act = 32'(fl_valid);
            K_RDY:   act = 32'(req_ready);
            K_FW:    act = 32'(fl_write);
            default: act = 32'(fl_addr);
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
         end
      end
   end

   task automatic expect_v(kind_e k, logic [31:0] v, string r);
      item_t it;
      it.kind = k; it.exp = v; it.req = r;
      exp_q.push_back(it);
   endtask

   task automatic step();
      @(posedge clk); #1;
      cfg_wr = 1'b0; cfg_be = '0; req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d, logic [1:0] be);
      step();
      cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
   endtask

   task automatic rd(logic [7:0] a, logic [15:0] e, string r);
      step();
      cfg_addr = a;
      expect_v(K_RD, 32'(e), r);
   endtask

   task automatic smi_chk(bit e, string r);
      step();
      expect_v(K_SMI, 32'(e), r);
   endtask

   task automatic req(bit w, bit rdy, logic [23:0] a, bit e_fv, bit e_rdy, string r);
      step();
      req_valid = 1'b1; req_write = w; fl_ready = rdy; req_addr = a;
      req_wdata = 8'h5A;
      expect_v(K_FV, 32'(e_fv), r);
      expect_v(K_RDY, 32'(e_rdy), r);
      if (e_fv) begin
         expect_v(K_FW, 32'(w), r);
         expect_v(K_FA, 32'(a), r);
      end
   endtask

   initial begin
      #80000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(CA, 16'h0000, "R1 ctrl");
      rd(SA, 16'h0000, "R1 stat");
      smi_chk(1'b0, "R1 smi");
      // R2 reserved bits
      wr(CA, 16'hFFFC, 2'b11);
      rd(CA, 16'h0000, "R2 ctrl reserved");
      wr(SA, 16'hFFFE, 2'b11);
      rd(SA, 16'h0000, "R2 stat reserved");
      // R10 upper lane only
      wr(CA, 16'h0003, 2'b10);
      rd(CA, 16'h0000, "R10 ctrl lane gated");
      // R4 write enable both ways, R8 no pulse while unlocked
      wr(CA, 16'h0001, 2'b01);
      smi_chk(1'b0, "R8 unlocked set");
      rd(CA, 16'h0001, "R4 wen set");
      wr(CA, 16'h0000, 2'b01);
      rd(CA, 16'h0000, "R4 wen clear");
      // R5 gating with write-enable 0
      req(1'b0, 1'b0, 24'h00ABCD, 1'b1, 1'b0, "R5 read fwd busy");
      req(1'b0, 1'b1, 24'h001234, 1'b1, 1'b1, "R5 read fwd ready");
      req(1'b1, 1'b0, 24'h000777, 1'b0, 1'b1, "R5 write dropped");
      // R9 drop flag
      rd(SA, 16'h0001, "R9 drop set");
      wr(SA, 16'h0000, 2'b01);
      rd(SA, 16'h0001, "R9 write 0 keeps");
      wr(SA, 16'h0001, 2'b10);
      rd(SA, 16'h0001, "R10 stat lane gated");
      wr(SA, 16'h0001, 2'b01);
      rd(SA, 16'h0000, "R9 cleared");
      // R9 drop wins over clear in same cycle
      wr(SA, 16'h0001, 2'b01);
      req_valid = 1'b1; req_write = 1'b1; fl_ready = 1'b0;
      rd(SA, 16'h0001, "R9 set beats clear");
      wr(SA, 16'h0001, 2'b01);
      // R6 forwarding with write-enable 1
      wr(CA, 16'h0001, 2'b01);
      req(1'b1, 1'b0, 24'h0000F0, 1'b1, 1'b0, "R6 write fwd busy");
      req(1'b1, 1'b1, 24'h0000F1, 1'b1, 1'b1, "R6 write fwd ready");
      rd(SA, 16'h0000, "R6 no drop");
      wr(CA, 16'h0001, 2'b01);
      smi_chk(1'b0, "R8 rewrite unlocked");
      wr(CA, 16'h0000, 2'b01);
      // R8 lock and enable in same write
      wr(CA, 16'h0003, 2'b01);
      smi_chk(1'b0, "R8 same write");
      rd(CA, 16'h0003, "R3 lock set");
      wr(CA, 16'h0000, 2'b11);
      rd(CA, 16'h0002, "R3 lock sticky");
      // R7 pulse
      wr(CA, 16'h0001, 2'b01);
      smi_chk(1'b1, "R7 pulse");
      smi_chk(1'b0, "R7 single cycle");
      rd(CA, 16'h0003, "R7 wen granted");
      wr(CA, 16'h0003, 2'b01);
      smi_chk(1'b0, "R8 rewrite locked");
      // R3 reset clears lock
      step();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      rd(CA, 16'h0000, "R3 reset clears");
      step();
      step();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule